// File: doc/BRIEF.md
# GPIO Edge-Interrupt Controller

A 32-bit general-purpose I/O peripheral behind a simple word-addressed register bus. Software drives pads through an output-data register and a per-bit drive-enable register. It reads the pad levels back through a read-only input register. A plain spare register is provided as scratch storage. The pad inputs pass through a two-flop synchronizer before anything else uses them, so the whole block runs on one system clock.

The input register is refreshed on every system clock by default. Software can instead refresh it only on an edge of a slow external sampling clock. That clock is synchronized and edge-detected inside the system clock domain, and a control bit picks its rising or falling edge. When the input register changes, each bit whose interrupt-enable bit is set can record an event in a sticky per-bit status register. A per-bit polarity register chooses a rising or a falling transition for each bit.

Interrupts are tracked by a two-state machine. QUIET moves to FLAGGED when a new event arrives while the global interrupt enable is set. FLAGGED returns to QUIET when software writes the control register with the flag bit at zero, unless a new event lands in that same cycle. The interrupt line is the registered AND of the global enable and the FLAGGED state.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the drive-enable (0x08), interrupt-enable (0x0C), polarity (0x10), control (0x18) and status (0x1C) registers read zero. `irq` is low and `pad_oe` is zero.
- R2: The output (0x04), drive-enable (0x08), polarity (0x10), interrupt-enable (0x0C) and spare (0x14) registers read back what was written. `pad_out` equals the output register and `pad_oe` equals the drive-enable register.
- R3: The input register (0x00) returns the pad levels three system clocks after a pad change. Bus writes to it have no effect.
- R4: A status bit is set only when its interrupt-enable bit is 1 and its input makes the selected transition. Polarity bit 1 selects a rise and 0 selects a fall. Status bits are sticky until software writes the status register.
- R5: Control bit 2 is the global interrupt enable. When it is 1 and a new event is recorded, control bit 3 (the flag) reads 1 on the same edge, and `irq` rises one clock later.
- R6: Writing the control register with bit 3 at 0 clears the flag, and `irq` falls one clock later. Writing bit 3 as 1 never sets the flag. Writing zero to the status register clears the status bits.
- R7: An event recorded in the same cycle as a clearing write survives that write, in both the status register and the flag.
- R8: Control bit 0 set means the input register updates only on a synchronized edge of `ext_clk`. With control bit 1 at 0 that edge is the rising one, and with bit 1 at 1 it is the falling one.
- R9: Reads of addresses outside 0x00-0x1C, or of addresses that are not word aligned, return zero. Writes to such addresses change no register.
- R10: With control bit 2 at 0, events are still recorded in the status register, but the flag stays 0 and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Pad input levels, asynchronous |
| ext_clk | input | 1 | External sampling clock, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Per-pad drive enable |
| irq | output | 1 | Level interrupt request |

## Verification
Register read-back is exercised through a vector table that mixes legal offsets, a write to the read-only input register, out-of-range and misaligned addresses, and an attempt to set the flag from software. This separates correct decoding from aliasing. Edge events are driven on single bits in both directions under both polarity settings, and with the per-bit and global enables set and clear. This tells a recorded transition apart from an ignored one, and a silent status bit apart from an interrupt. One event is timed against a status write that lands on the same edge, to show that the event is not lost. In external-clock mode the pads change between clock edges of the wrong and the right polarity, which shows that only the selected edge refreshes the input register.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
    // word slots (byte offset / 4)
    localparam logic [2:0] SLOT_IN    = 3'd0;
    localparam logic [2:0] SLOT_OUT   = 3'd1;
    localparam logic [2:0] SLOT_OE    = 3'd2;
    localparam logic [2:0] SLOT_INTE  = 3'd3;
    localparam logic [2:0] SLOT_POL   = 3'd4;
    localparam logic [2:0] SLOT_SPARE = 3'd5;
    localparam logic [2:0] SLOT_CTRL  = 3'd6;
    localparam logic [2:0] SLOT_STAT  = 3'd7;

    // control bit positions
    localparam int CB_EXT  = 0;
    localparam int CB_NEG  = 1;
    localparam int CB_GIE  = 2;
    localparam int CB_FLAG = 3;

    typedef enum logic {
        IRQ_QUIET   = 1'b0,
        IRQ_FLAGGED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_in_sampler.sv
`timescale 1ns/1ps
module gpio_in_sampler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic         ext_clk,
    input  logic         use_ext,
    input  logic         neg_sel,
    output logic [W-1:0] in_q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic         take
);
    localparam int EXT_STAGES = 3;

    logic [W-1:0]          sync1, sync2;
    logic [EXT_STAGES-1:0] ext_pipe;
    logic                  ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1    <= '0;
            sync2    <= '0;
            ext_pipe <= '0;
            in_q     <= '0;
        end else begin
            sync1    <= pad_in;
            sync2    <= sync1;
            ext_pipe <= {ext_pipe[EXT_STAGES-2:0], ext_clk};
            if (take) in_q <= sync2;
        end
    end

    always_comb begin
        ext_rise = ext_pipe[1] & ~ext_pipe[2];
        ext_fall = ~ext_pipe[1] & ext_pipe[2];
        take     = use_ext ? (neg_sel ? ext_fall : ext_rise) : 1'b1;
        rise     = take ? (sync2 & ~in_q) : '0;
        fall     = take ? (~sync2 & in_q) : '0;
    end
endmodule

// File: rtl/gpio_irq_fsm.sv
`timescale 1ns/1ps
module gpio_irq_fsm
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_any,
    input  logic gie,
    input  logic clr_req,
    output logic flag,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (ev_any && gie) state_d = IRQ_FLAGGED;
            IRQ_FLAGGED: if (clr_req && !(ev_any && gie)) state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gie && (state_q == IRQ_FLAGGED);
    end

    assign flag = (state_q == IRQ_FLAGGED);
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    input  logic              ext_clk,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              irq
);
    localparam int NSLOT   = 8;
    localparam int CTRL_W  = 3;

    logic [2:0]        slot;
    logic              mapped;
    logic [NSLOT-1:0]  wr_hit;
    logic [W-1:0]      out_q, oe_q, inte_q, pol_q, spare_q, ints_q, ints_base;
    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      in_q, rise, fall, ev;
    logic              take, ev_any, flag, gie, use_ext, clr_req, ints_wr;

    assign slot   = bus_addr[4:2];
    assign mapped = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);

    always_comb begin
        wr_hit = '0;
        if (bus_wr && mapped) wr_hit[slot] = 1'b1;
    end

    assign gie     = ctrl_q[CB_GIE];
    assign use_ext = ctrl_q[CB_EXT];
    assign clr_req = wr_hit[SLOT_CTRL] && !bus_wdata[CB_FLAG];
    assign ints_wr = wr_hit[SLOT_STAT];

    gpio_in_sampler #(.W(W)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .ext_clk (ext_clk),
        .use_ext (use_ext),
        .neg_sel (ctrl_q[CB_NEG]),
        .in_q    (in_q),
        .rise    (rise),
        .fall    (fall),
        .take    (take)
    );

    for (genvar i = 0; i < W; i++) begin : g_evt
        assign ev[i] = inte_q[i] & (pol_q[i] ? rise[i] : fall[i]);
    end
    assign ev_any = |ev;

    assign ints_base = ints_wr ? bus_wdata : ints_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            oe_q    <= '0;
            inte_q  <= '0;
            pol_q   <= '0;
            spare_q <= '0;
            ctrl_q  <= '0;
            ints_q  <= '0;
        end else begin
            if (wr_hit[SLOT_OUT])   out_q   <= bus_wdata;
            if (wr_hit[SLOT_OE])    oe_q    <= bus_wdata;
            if (wr_hit[SLOT_INTE])  inte_q  <= bus_wdata;
            if (wr_hit[SLOT_POL])   pol_q   <= bus_wdata;
            if (wr_hit[SLOT_SPARE]) spare_q <= bus_wdata;
            if (wr_hit[SLOT_CTRL])  ctrl_q  <= bus_wdata[CTRL_W-1:0];
            ints_q <= ints_base | ev;
        end
    end

    gpio_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_any  (ev_any),
        .gie     (gie),
        .clr_req (clr_req),
        .flag    (flag),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (slot)
                SLOT_IN:    bus_rdata = in_q;
                SLOT_OUT:   bus_rdata = out_q;
                SLOT_OE:    bus_rdata = oe_q;
                SLOT_INTE:  bus_rdata = inte_q;
                SLOT_POL:   bus_rdata = pol_q;
                SLOT_SPARE: bus_rdata = spare_q;
                SLOT_CTRL:  bus_rdata = {{(W-CTRL_W-1){1'b0}}, flag, ctrl_q};
                SLOT_STAT:  bus_rdata = ints_q;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = oe_q;
endmodule

// File: rtl/gpio_edge_chk.sv
`timescale 1ns/1ps
module gpio_edge_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flag,
    input logic         gie,
    input logic         irq,
    input logic         ev_any,
    input logic         take,
    input logic         use_ext,
    input logic         ints_wr,
    input logic [W-1:0] in_q,
    input logic [W-1:0] ints_q
);
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && gie) |=> irq);

    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> !irq);

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_any && gie) |=> flag);

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ints_wr && !ev_any) |=> (ints_q == $past(ints_q)));

    assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && !take) |=> $stable(in_q));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq);
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag    (flag),
    .gie     (gie),
    .irq     (irq),
    .ev_any  (ev_any),
    .take    (take),
    .use_ext (use_ext),
    .ints_wr (ints_wr),
    .in_q    (in_q),
    .ints_q  (ints_q)
);

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  b_addr = '0;
    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [31:0] drv = '0;
    logic [31:0] pad_in, pad_out, pad_oe;
    logic        ext_clk = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & drv);

    gpio_edge_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .pad_in(pad_in),
        .ext_clk(ext_clk), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {addr, write data, expected read}
    localparam logic [69:0] VEC [0:8] = '{
        {6'h00, 32'hFFFF_FFFF, 32'hA5A5_0F0F},  // R3 write ignored
        {6'h04, 32'h1234_5678, 32'h1234_5678},  // R2
        {6'h08, 32'h0000_FFFF, 32'h0000_FFFF},  // R2
        {6'h00, 32'h0000_0000, 32'hA5A5_5678},  // R3 driven bits read back
        {6'h10, 32'h0F0F_F0F0, 32'h0F0F_F0F0},  // R2
        {6'h14, 32'hCAFE_0001, 32'hCAFE_0001},  // R2
        {6'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 out of range
        {6'h06, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 misaligned
        {6'h18, 32'h0000_0008, 32'h0000_0000}   // R6 flag not settable
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        b_addr = a;
        #1;
        d = b_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [31:0] rd, held;
        drv = 32'hA5A5_0F0F;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        wait_n(4);

        // R1 reset values
        bus_read(6'h08, rd); check("R1 drive-enable", rd, 0);
        bus_read(6'h0C, rd); check("R1 int-enable", rd, 0);
        bus_read(6'h10, rd); check("R1 polarity", rd, 0);
        bus_read(6'h18, rd); check("R1 control", rd, 0);
        bus_read(6'h1C, rd); check("R1 status", rd, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 pad_oe", pad_oe, 0);

        for (int i = 0; i < 9; i++) begin
            bus_write(VEC[i][69:64], VEC[i][63:32]);
            wait_n(4);
            bus_read(VEC[i][69:64], rd);
            check($sformatf("table row %0d (R2/R3/R9/R6)", i), rd, VEC[i][31:0]);
        end
        check("R2 pad_out", pad_out, 32'h1234_5678);
        check("R2 pad_oe", pad_oe, 32'h0000_FFFF);

        bus_write(6'h24, 32'h0);
        bus_read(6'h04, rd); check("R9 out unchanged", rd, 32'h1234_5678);
        bus_read(6'h14, rd); check("R9 spare unchanged", rd, 32'hCAFE_0001);

        // quiet setup
        bus_write(6'h08, 0); bus_write(6'h04, 0);
        drv = 0; wait_n(6);
        bus_write(6'h10, 32'h1);       // bit0 rising, bit1 falling
        bus_write(6'h0C, 32'h3);
        bus_write(6'h18, 32'h4);       // global enable

        // R5 timing on a rising edge of bit 0
        @(negedge clk) drv[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 irq not yet", {31'b0, irq}, 0);
        bus_read(6'h18, rd); check("R5 flag set", rd, 32'hC);
        bus_read(6'h1C, rd); check("R4 rise recorded", rd, 32'h1);
        bus_read(6'h00, rd); check("R3 latency", rd, 32'h1);
        @(negedge clk);
        check("R5 irq high", {31'b0, irq}, 1);

        // R6 acknowledge
        bus_write(6'h18, 32'h4);
        bus_write(6'h1C, 32'h0);
        check("R6 irq low", {31'b0, irq}, 0);
        bus_read(6'h18, rd); check("R6 flag cleared", rd, 32'h4);
        bus_read(6'h1C, rd); check("R6 status cleared", rd, 0);

        // R4 falling polarity on bit 1
        drv[1] = 1'b1; wait_n(6);
        bus_read(6'h1C, rd); check("R4 rise ignored when polarity 0", rd, 0);
        drv[1] = 1'b0; wait_n(6);
        bus_read(6'h1C, rd); check("R4 fall recorded", rd, 32'h2);
        check("R5 irq from fall", {31'b0, irq}, 1);
        bus_write(6'h18, 32'h4); bus_write(6'h1C, 32'h0);

        // R4 disabled bit
        bus_write(6'h10, 32'h5);
        drv[2] = 1'b1; wait_n(6);
        bus_read(6'h1C, rd); check("R4 disabled bit silent", rd, 0);
        check("R4 irq silent", {31'b0, irq}, 0);

        // R7 event versus clearing write on the same edge
        drv[0] = 1'b0; wait_n(6);
        drv[1] = 1'b1; wait_n(6);
        drv[1] = 1'b0; wait_n(6);      // status = bit1
        @(negedge clk) drv[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); b_addr = 6'h1C; b_wdata = 0; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0;
        bus_read(6'h1C, rd); check("R7 event survives clear", rd, 32'h1);
        bus_write(6'h18, 32'h4); bus_write(6'h1C, 32'h0);

        // R10 global enable off
        bus_write(6'h18, 32'h0);
        drv[1] = 1'b1; wait_n(6);
        drv[1] = 1'b0; wait_n(6);
        bus_read(6'h1C, rd); check("R10 status recorded", rd, 32'h2);
        bus_read(6'h18, rd); check("R10 flag stays 0", rd, 0);
        check("R10 irq low", {31'b0, irq}, 0);
        bus_write(6'h1C, 32'h0);

        // R8 external sampling clock
        bus_write(6'h0C, 32'h0);
        bus_write(6'h18, 32'h1);
        held = drv;
        drv = 32'h0000_00F0; wait_n(8);
        bus_read(6'h00, rd); check("R8 held without edge", rd, held);
        ext_clk = 1'b1; wait_n(6);
        bus_read(6'h00, rd); check("R8 rising edge samples", rd, 32'h0000_00F0);
        drv = 32'h0000_000F; ext_clk = 1'b0; wait_n(6);
        bus_read(6'h00, rd); check("R8 falling ignored in rising mode", rd, 32'h0000_00F0);
        bus_write(6'h18, 32'h3);
        ext_clk = 1'b1; wait_n(6);
        bus_read(6'h00, rd); check("R8 rising ignored in falling mode", rd, 32'h0000_00F0);
        ext_clk = 1'b0; wait_n(6);
        bus_read(6'h00, rd); check("R8 falling edge samples", rd, 32'h0000_000F);
        bus_write(6'h18, 32'h0); wait_n(6);
        bus_read(6'h00, rd); check("R3 free-running again", rd, 32'h0000_000F);

        finish_run();
    end
endmodule